// File: doc/BRIEF.md
# Programmable FFT Stage Address Generator

This block produces the index stream for one butterfly stage of a mixed-radix FFT. In data mode it walks the memory addresses that the stage reads. In twiddle mode it walks the exponents that select the rotation factors. The same nested-loop engine serves a plain one-dimensional FFT and a multidimensional FFT that has been folded onto a one-dimensional FFT of the same total size. Only the stage parameters change between the two cases, so no transpose pass is needed between dimensions.

A controller programs a stage by pulsing `start_i` while the parameters sit on the inputs. The block captures them on that edge. From the next cycle on it emits one index per cycle unless `stall_i` holds it back, and it flags the final index of the stage. Twiddle exponents are reduced modulo the total point count, so they can address a single table with one entry per point.

Top module: `fft_stage_agen`

## Requirements
- R1: While reset is asserted and after it is released, until the first start, `valid_o` and `last_o` are 0.
- R2: A start pulse captures every parameter input on that edge. The first index appears with `valid_o`=1 in the next cycle and has the value 0. Parameter changes after the start pulse do not alter the running sequence.
- R3: In data mode (`mode_i`=0), with stride G=`outer_cnt_i` and span L=`mid_cnt_i`, the outer loop k runs over 0..G-1 and the inner loop l runs over 0..L-1. Each step emits l*G+k, for G*L indices in total.
- R4: In twiddle mode (`mode_i`=1), with K=`outer_cnt_i`, L=`mid_cnt_i`, R=`radix_i`, w=`step_i` and N=`npts_i`, the loops run k outermost, then l, then m innermost. Each step emits (m*k*w) mod N, for K*L*R indices in total, and every emitted exponent is below N.
- R5: When `stall_i` is 0 the block moves to the next index every cycle. When `stall_i` is 1 the index, `valid_o` and `last_o` hold their values, and while idle `valid_o` stays 0.
- R6: `last_o` is 1 only together with the final index of the stage. After that index is accepted, `valid_o` is 0 in the next cycle.
- R7: A loop count of 0 on `outer_cnt_i`, `mid_cnt_i` or `radix_i` acts as a count of 1. It gives a single iteration, and in data mode a stride of 1.
- R8: A start pulse during a running stage abandons that stage. The new stage begins in the next cycle from index 0.
- R9: In data mode `radix_i`, `step_i` and `npts_i` have no effect on the emitted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Captures parameters and starts a stage |
| mode_i | input | 1 | 0 selects data addresses, 1 selects twiddle exponents |
| outer_cnt_i | input | AW | Outer loop count (data stride G or twiddle K) |
| mid_cnt_i | input | AW | Middle loop count L |
| radix_i | input | AW | Inner loop count R (twiddle only) |
| step_i | input | AW | Exponent step w (twiddle only, below N) |
| npts_i | input | AW+1 | Total point count N used as exponent modulus |
| stall_i | input | 1 | Holds the current index |
| addr_o | output | AW | Data address or twiddle exponent |
| valid_o | output | 1 | Index on addr_o is meaningful |
| last_o | output | 1 | Current index is the final one of the stage |

## Verification
The bench runs the four data stages of a 36-point 3,2,2,3 transform, where the stride steps down 12, 6, 3, 1. A design that mixes up the loop order or the stride emits a permutation that differs from the first few addresses on. Zero loop counts are driven on each loop in turn: a sequencer that takes 0 literally either hangs, which the watchdog catches, or wraps through thousands of indices. A restart is issued in the middle of a stage, and heavy random stalls are applied. An engine that advances under a stall, or keeps stale accumulator state after a restart, skips or corrupts indices. Random twiddle runs with odd moduli expose a missing or single-sided modular reduction as exponents at or above N.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  typedef enum logic {
    MODE_DATA = 1'b0,
    MODE_TWID = 1'b1
  } agen_mode_e;

  // loop index 0 = innermost (m), 1 = middle (l), 2 = outermost (k)
  localparam int unsigned LOOPS = 3;
  localparam int unsigned LP_M  = 0;
  localparam int unsigned LP_L  = 1;
  localparam int unsigned LP_K  = 2;
endpackage

// File: rtl/agen_loop_ctr.sv
module agen_loop_ctr #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [CW-1:0] max_i,
  output logic          at_max_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en   = clr_i | adv_i;
  assign at_max_o = (cnt_q == max_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (at_max_o) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/agen_acc.sv
module agen_acc #(
  parameter int unsigned AW = 10,
  parameter int unsigned NL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [NL-1:0] inc_i,
  input  logic [NL-1:0] wrap_i,
  input  logic [AW-1:0] stride_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW:0]   npts_i,
  output logic [AW-1:0] data_o,
  output logic [AW-1:0] twid_o
);
  import fsa_pkg::*;

  logic [AW-1:0] d_acc_q, d_acc_d, d_row_q, d_row_d;
  logic [AW-1:0] t_acc_q, t_acc_d, t_base_q, t_base_d;
  logic          acc_en;

  function automatic logic [AW-1:0] mod_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= npts_i) s = s - npts_i;
    return s[AW-1:0];
  endfunction

  assign acc_en = clr_i | (|inc_i) | (|wrap_i);

  always_comb begin
    d_acc_d  = d_acc_q;
    d_row_d  = d_row_q;
    t_acc_d  = t_acc_q;
    t_base_d = t_base_q;
    if (clr_i) begin
      d_acc_d  = '0;
      d_row_d  = '0;
      t_acc_d  = '0;
      t_base_d = '0;
    end else begin
      // data: new column restarts at k, new row adds the stride
      if (inc_i[LP_K]) begin
        d_row_d = d_row_q + 1'b1;
        d_acc_d = d_row_q + 1'b1;
      end else if (inc_i[LP_L]) begin
        d_acc_d = d_acc_q + stride_i;
      end
      // twiddle: base tracks k*w, accumulator tracks m*base
      if (inc_i[LP_K])       t_base_d = mod_add(t_base_q, step_i);
      if (inc_i[LP_M])       t_acc_d  = mod_add(t_acc_q, t_base_q);
      else if (wrap_i[LP_M]) t_acc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_acc_q  <= '0;
      d_row_q  <= '0;
      t_acc_q  <= '0;
      t_base_q <= '0;
    end else if (acc_en) begin
      d_acc_q  <= d_acc_d;
      d_row_q  <= d_row_d;
      t_acc_q  <= t_acc_d;
      t_base_q <= t_base_d;
    end
  end

  assign data_o = d_acc_q;
  assign twid_o = t_acc_q;
endmodule

// File: rtl/fft_stage_agen.sv
module fft_stage_agen #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] outer_cnt_i,
  input  logic [AW-1:0] mid_cnt_i,
  input  logic [AW-1:0] radix_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW:0]   npts_i,
  input  logic          stall_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          last_o
);
  import fsa_pkg::*;

  localparam int unsigned CW = AW;

  agen_mode_e    cfg_mode_q, cfg_mode_d;
  logic [CW-1:0] cfg_max_q [LOOPS];
  logic [CW-1:0] cfg_max_d [LOOPS];
  logic [AW-1:0] cfg_stride_q, cfg_stride_d;
  logic [AW-1:0] cfg_step_q, cfg_step_d;
  logic [AW:0]   cfg_npts_q, cfg_npts_d;
  logic          busy_q, busy_d;

  logic [LOOPS-1:0] adv, at_max, inc, wrap;
  logic             fire, all_max;
  logic [AW-1:0]    data_idx, twid_idx;

  function automatic logic [CW-1:0] cnt_to_max(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // configuration capture
  always_comb begin
    cfg_mode_d         = agen_mode_e'(mode_i);
    cfg_max_d[LP_K]    = cnt_to_max(outer_cnt_i);
    cfg_max_d[LP_L]    = cnt_to_max(mid_cnt_i);
    cfg_max_d[LP_M]    = (agen_mode_e'(mode_i) == MODE_TWID) ? cnt_to_max(radix_i) : '0;
    cfg_stride_d       = (outer_cnt_i == '0) ? AW'(1) : outer_cnt_i;
    cfg_step_d         = step_i;
    cfg_npts_d         = npts_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode_q   <= MODE_DATA;
      cfg_stride_q <= '0;
      cfg_step_q   <= '0;
      cfg_npts_q   <= '0;
      for (int i = 0; i < int'(LOOPS); i++) cfg_max_q[i] <= '0;
    end else if (start_i) begin
      cfg_mode_q   <= cfg_mode_d;
      cfg_stride_q <= cfg_stride_d;
      cfg_step_q   <= cfg_step_d;
      cfg_npts_q   <= cfg_npts_d;
      for (int i = 0; i < int'(LOOPS); i++) cfg_max_q[i] <= cfg_max_d[i];
    end
  end

  // sequencing
  assign fire    = busy_q & ~stall_i;
  assign all_max = &at_max;
  assign adv[0]  = fire & ~all_max;

  genvar gi;
  generate
    for (gi = 1; gi < int'(LOOPS); gi++) begin : g_chain
      assign adv[gi] = adv[gi-1] & at_max[gi-1];
    end
    for (gi = 0; gi < int'(LOOPS); gi++) begin : g_loop
      assign inc[gi]  = adv[gi] & ~at_max[gi];
      assign wrap[gi] = adv[gi] &  at_max[gi];
      agen_loop_ctr #(.CW(CW)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_i),
        .adv_i    (adv[gi]),
        .max_i    (cfg_max_q[gi]),
        .at_max_o (at_max[gi])
      );
    end
  endgenerate

  always_comb begin
    busy_d = busy_q;
    if (start_i)             busy_d = 1'b1;
    else if (fire & all_max) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  agen_acc #(.AW(AW), .NL(LOOPS)) i_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (start_i),
    .inc_i    (inc),
    .wrap_i   (wrap),
    .stride_i (cfg_stride_q),
    .step_i   (cfg_step_q),
    .npts_i   (cfg_npts_q),
    .data_o   (data_idx),
    .twid_o   (twid_idx)
  );

  assign addr_o  = (cfg_mode_q == MODE_TWID) ? twid_idx : data_idx;
  assign valid_o = busy_q;
  assign last_o  = busy_q & all_max;
endmodule

// File: rtl/fft_stage_agen_chk.sv
module fft_stage_agen_chk #(
  parameter int unsigned AW = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                stall_i,
  input logic [AW-1:0]       addr_o,
  input logic                valid_o,
  input logic                last_o,
  input fsa_pkg::agen_mode_e cfg_mode_q,
  input logic [AW:0]         cfg_npts_q
);
  import fsa_pkg::*;

  // R1
  quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);

  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && addr_o == '0));

  // R4
  twid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_mode_q == MODE_TWID) |-> ({1'b0, addr_o} < cfg_npts_q));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stall_i && !start_i) |=> (valid_o && $stable(addr_o) && $stable(last_o)));

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R6
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !stall_i && !start_i) |=> !valid_o);
endmodule

bind fft_stage_agen fft_stage_agen_chk #(.AW(AW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .stall_i    (stall_i),
  .addr_o     (addr_o),
  .valid_o    (valid_o),
  .last_o     (last_o),
  .cfg_mode_q (cfg_mode_q),
  .cfg_npts_q (cfg_npts_q)
);

// File: tb/test_fft_stage_agen.sv
module test_fft_stage_agen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk, rst_n, start_i, mode_i, stall_i;
  logic [AW-1:0] outer_cnt_i, mid_cnt_i, radix_i, step_i, addr_o;
  logic [AW:0]   npts_i;
  logic          valid_o, last_o;

  int n_pass = 0;
  int n_fail = 0;

  fft_stage_agen #(.AW(AW)) i_fft_stage_agen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .outer_cnt_i(outer_cnt_i), .mid_cnt_i(mid_cnt_i), .radix_i(radix_i),
    .step_i(step_i), .npts_i(npts_i), .stall_i(stall_i),
    .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic longint exp_idx(input bit md, input int g, input int k, input int l,
                                     input int m, input int w, input int n);
    if (md) return (longint'(m) * k * w) % n;
    return longint'(l) * eff(g) + k;
  endfunction

  // assumes it is called at a falling edge
  task automatic run(input bit md, input int g, input int l_cnt, input int r, input int w,
                     input int n, input int stall_pct, input int abort_at, input string tag);
    int kc, lc, rc, total, idx;
    longint e;
    bit last_exp;
    start_i     = 1'b1;
    mode_i      = md;
    outer_cnt_i = AW'(g);
    mid_cnt_i   = AW'(l_cnt);
    radix_i     = AW'(r);
    step_i      = AW'(w);
    npts_i      = (AW+1)'(n);
    stall_i     = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // parameters move after capture: must have no effect (R2)
    mode_i      = ~md;
    outer_cnt_i = AW'($urandom);
    mid_cnt_i   = AW'($urandom);
    radix_i     = AW'($urandom);
    step_i      = AW'($urandom);
    npts_i      = (AW+1)'($urandom);
    kc = eff(g);
    lc = eff(l_cnt);
    rc = md ? eff(r) : 1;
    total = kc * lc * rc;
    idx = 0;
    for (int k = 0; k < kc; k++)
      for (int l = 0; l < lc; l++)
        for (int m = 0; m < rc; m++) begin
          if (abort_at >= 0 && idx == abort_at) return;
          e = exp_idx(md, g, k, l, m, w, n);
          last_exp = (idx == total - 1);
          do begin
            check(valid_o === 1'b1, tag, valid_o, 1);
            check(longint'(addr_o) == e, tag, addr_o, e);
            check(last_o === last_exp, {tag, "/R6"}, last_o, last_exp);
            stall_i = (($urandom % 100) < stall_pct);
            @(negedge clk);
          end while (stall_i);
          idx++;
        end
    check(valid_o === 1'b0, "R6 end of stage", valid_o, 0);
    check(last_o === 1'b0, "R6 end of stage", last_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R5 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    int g, l, r, n, w;
    bit md;
    void'($urandom(32'd4127));
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; stall_i = 1'b0;
    outer_cnt_i = '0; mid_cnt_i = '0; radix_i = '0; step_i = '0; npts_i = '0;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && last_o === 1'b0, "R1 in reset", {valid_o, last_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && last_o === 1'b0, "R1 idle after reset", {valid_o, last_o}, 0);

    // R3: data stages of a 36-point 3,2,2,3 transform
    run(1'b0, 12, 3, 0, 0, 36, 0, -1, "R3 stride12");
    run(1'b0, 6, 6, 0, 0, 36, 0, -1, "R3 stride6");
    run(1'b0, 3, 12, 0, 0, 36, 0, -1, "R3 stride3");
    run(1'b0, 1, 36, 0, 0, 36, 0, -1, "R3 stride1");
    // R4: twiddle stages
    run(1'b1, 4, 3, 3, 3, 36, 0, -1, "R4 twid36");
    run(1'b1, 6, 2, 2, 6, 36, 0, -1, "R4 twid2d");
    run(1'b1, 5, 1, 7, 11, 13, 0, -1, "R4 twid mod13");
    // R7: zero counts
    run(1'b0, 0, 5, 0, 0, 36, 0, -1, "R7 zero stride");
    run(1'b0, 4, 0, 0, 0, 36, 0, -1, "R7 zero span");
    run(1'b1, 3, 2, 0, 5, 36, 0, -1, "R7 zero radix");
    run(1'b0, 0, 0, 0, 0, 36, 0, -1, "R7 all zero");
    // R9: data mode ignores twiddle-only inputs
    run(1'b0, 3, 4, 7, 999, 5, 0, -1, "R9 data ignores radix");
    // R5: heavy stalling
    run(1'b1, 4, 2, 4, 9, 64, 60, -1, "R5 stalled twid");
    run(1'b0, 5, 3, 0, 0, 64, 60, -1, "R5 stalled data");
    // R8: restart mid-stage
    run(1'b0, 8, 8, 0, 0, 64, 0, 5, "R8 aborted");
    run(1'b1, 3, 3, 3, 7, 50, 20, -1, "R8 restarted twid");
    run(1'b1, 6, 6, 4, 5, 100, 0, 9, "R8 aborted twid");
    run(1'b0, 4, 4, 0, 0, 16, 0, -1, "R8 restarted data");
    // constrained random
    for (int t = 0; t < 24; t++) begin
      md = $urandom % 2;
      g  = $urandom % 9;
      l  = $urandom % 9;
      r  = $urandom % 6;
      n  = 1 + ($urandom % 1024);
      w  = $urandom % n;
      if (md) run(1'b1, g, l, r, w, n, 30, -1, "R4 random");
      else    run(1'b0, g, l, r, w, n, 30, -1, "R3 random");
    end
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule